// File: doc/BRIEF.md
# Four-Channel Block-Transfer Engine

The engine moves blocks of data from one memory address range to another on behalf of a processor, with four independent channels. Each channel is programmed through a small register port with a source address, a destination address, a unit count and a control word. Once enabled, a channel performs its transfer over a single master bus port. It reads one unit and then writes it, and it continues until the count is used up. Units are 16 or 32 bits wide.

A channel can start as soon as it is enabled, or wait for a horizontal-blank or vertical-blank pulse from the display timing. When a channel is enabled, it takes private working copies of its address and count registers. Software may then reprogram the registers for the next run without disturbing the run in progress. When a run ends, the channel either switches itself off, or it reloads and waits for its next trigger. It can also raise its own completion interrupt.

Top module: `dma4_engine`

## Requirements
- R1: A write to a source or destination address register stores the value with bit 0 forced to zero, and reading the register back shows that value.
- R2: Control bit 10 selects the unit size. When it is set, units are 4 bytes, the address step is 4 and the bus address has bits 1:0 at zero. When it is clear, units are 2 bytes, the step is 2 and bus address bit 0 is zero.
- R3: The source mode (control bits 8:7) and the destination mode (control bits 6:5) use these codes: 0 increments by one unit per transfer, 1 decrements by one unit, 2 keeps the address fixed, and 3 increments and also reloads on repeat.
- R4: A programmed count of zero means 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3. Any other value means that many units.
- R5: The working source, destination and count are copied from the programmed registers only when control bit 15 (enable) changes from 0 to 1. Later register writes do not affect a run that is already armed.
- R6: The trigger field (control bits 13:12) uses these codes: 0 starts on enable, 1 starts on each vertical-blank pulse, 2 starts on each horizontal-blank pulse, and 3 never starts a transfer.
- R7: Channels that are pending at the same time are served one whole run after another, lowest channel number first.
- R8: Each unit is a bus read followed by a bus write of the read data. A request, its address and its direction are held until the request is acknowledged.
- R9: When a run without repeat (control bit 9 clear) ends, the control register becomes its previous value AND 0x7FE0. This clears enable and bits 4:0.
- R10: When a run with repeat ends, enable stays set and the working count reloads. The working destination reloads from the programmed destination only in destination mode 3. The channel then waits for its next trigger.
- R11: When a run ends with control bit 14 set, the channel's interrupt output pulses for exactly one cycle. With bit 14 clear, no pulse appears.
- R12: After reset there is no bus request, no interrupt, and all programmed registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by a write |
| cfg_sel | input | 2 | Register addressed: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| rd_ch | input | 2 | Channel addressed by a read |
| rd_sel | input | 2 | Register addressed by a read (same codes as cfg_sel) |
| rd_data | output | 32 | Read data, combinational |
| hblank_pulse | input | 1 | Horizontal-blank trigger, one cycle |
| vblank_pulse | input | 1 | Vertical-blank trigger, one cycle |
| bus_req | output | 1 | Master request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_word | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| bus_addr | output | 32 | Unit address |
| bus_wdata | output | 32 | Write data (the data just read) |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Completes the current request |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench uses several runs that differ in one respect each, so that the effect of each setting can be seen on its own:
- A misaligned, incrementing 32-bit run checks alignment, stepping and the clearing of enable.
- A decrementing-source, fixed-destination 16-bit run checks the other two address modes and confirms that no interrupt appears when bit 14 is clear.
- Two vertical-blank channels armed together, with a horizontal-blank pulse sent first, check trigger matching and service order. Rewriting the registers after arming shows that the working copies are isolated.
- Two repeating horizontal-blank channels, one with destination reload and one with plain increment, tell the reload mode apart from ordinary stepping over two pulses.
- A channel with trigger code 3 must stay silent.
- A zero-count run on channel 0 must produce exactly 0x4000 units.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    ADR_INC     = 2'd0,
    ADR_DEC     = 2'd1,
    ADR_FIX     = 2'd2,
    ADR_INC_RLD = 2'd3
  } adr_mode_e;

  typedef enum logic [1:0] {
    TRG_NOW     = 2'd0,
    TRG_VBLANK  = 2'd1,
    TRG_HBLANK  = 2'd2,
    TRG_SPECIAL = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_e;

  // control word bit positions
  localparam int CTL_DST_LSB = 5;
  localparam int CTL_SRC_LSB = 7;
  localparam int CTL_RPT     = 9;
  localparam int CTL_WORD    = 10;
  localparam int CTL_TRG_LSB = 12;
  localparam int CTL_IE      = 14;
  localparam int CTL_EN      = 15;
  localparam logic [15:0] CTL_KEEP_MASK = 16'h7FE0;

  function automatic logic [31:0] step_addr(input logic [31:0] a,
                                            input adr_mode_e mode,
                                            input logic word);
    logic [31:0] unit;
    unit = word ? 32'd4 : 32'd2;
    case (mode)
      ADR_DEC: step_addr = a - unit;
      ADR_FIX: step_addr = a;
      default: step_addr = a + unit;
    endcase
  endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int ZERO_CNT = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             hblank,
  input  logic             vblank,
  input  logic             active,
  input  logic             unit_done,
  output logic             pend_o,
  output logic [31:0]      wsrc_o,
  output logic [31:0]      wdst_o,
  output logic             word_o,
  output logic             last_o,
  output logic [31:0]      src_reg_o,
  output logic [31:0]      dst_reg_o,
  output logic [15:0]      cnt_reg_o,
  output logic [15:0]      ctl_reg_o,
  output logic             irq_o
);

  logic [31:0]      src_q, src_d, dst_q, dst_d, wsrc_q, wsrc_d, wdst_q, wdst_d;
  logic [15:0]      cnt_q, cnt_d, ctl_q, ctl_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d, reload;
  logic             pend_q, pend_d, irq_q, irq_d;
  logic             finish, ctl_wr;
  trig_e            trg;
  adr_mode_e        smode, dmode;

  assign trg    = trig_e'(ctl_q[CTL_TRG_LSB +: 2]);
  assign smode  = adr_mode_e'(ctl_q[CTL_SRC_LSB +: 2]);
  assign dmode  = adr_mode_e'(ctl_q[CTL_DST_LSB +: 2]);
  assign reload = (cnt_q == 16'd0) ? CNT_W'(ZERO_CNT) : CNT_W'(cnt_q);
  assign finish = active && unit_done && last_o;
  assign ctl_wr = wr_en && (wr_sel == SEL_CTL);

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    ctl_d  = ctl_q;
    wsrc_d = wsrc_q;
    wdst_d = wdst_q;
    wcnt_d = wcnt_q;
    pend_d = pend_q;
    irq_d  = 1'b0;
    // blank-timed triggers
    if (ctl_q[CTL_EN] && !pend_q &&
        (((trg == TRG_VBLANK) && vblank) || ((trg == TRG_HBLANK) && hblank)))
      pend_d = 1'b1;
    // unit progress and end of run
    if (active && unit_done) begin
      wsrc_d = step_addr(wsrc_q, smode, ctl_q[CTL_WORD]);
      wdst_d = step_addr(wdst_q, dmode, ctl_q[CTL_WORD]);
      wcnt_d = wcnt_q - CNT_W'(1);
      if (last_o) begin
        pend_d = 1'b0;
        irq_d  = ctl_q[CTL_IE];
        if (ctl_q[CTL_RPT]) begin
          wcnt_d = reload;
          if (dmode == ADR_INC_RLD) wdst_d = dst_q;
        end else begin
          ctl_d = ctl_q & CTL_KEEP_MASK;
        end
      end
    end
    // register writes
    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_SRC: src_d = {wr_data[31:1], 1'b0};
        SEL_DST: dst_d = {wr_data[31:1], 1'b0};
        SEL_CNT: cnt_d = wr_data[15:0];
        default: begin
          ctl_d = wr_data[15:0];
          if (wr_data[CTL_EN] && !ctl_q[CTL_EN]) begin
            wsrc_d = src_q;
            wdst_d = dst_q;
            wcnt_d = reload;
            pend_d = (trig_e'(wr_data[CTL_TRG_LSB +: 2]) == TRG_NOW);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      wsrc_q <= '0;
      wdst_q <= '0;
      wcnt_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      wsrc_q <= wsrc_d;
      wdst_q <= wdst_d;
      wcnt_q <= wcnt_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o    = pend_q;
  assign wsrc_o    = wsrc_q;
  assign wdst_o    = wdst_q;
  assign word_o    = ctl_q[CTL_WORD];
  assign last_o    = (wcnt_q == CNT_W'(1));
  assign src_reg_o = src_q;
  assign dst_reg_o = dst_q;
  assign cnt_reg_o = cnt_q;
  assign ctl_reg_o = ctl_q;
  assign irq_o     = irq_q;

  assert_addr_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q[0] == 1'b0) && (dst_q[0] == 1'b0));

  assert_enable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !ctl_q[CTL_RPT] && !ctl_wr) |=> !ctl_q[CTL_EN]);

  assert_repeat_keeps_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && ctl_q[CTL_RPT] && ctl_q[CTL_EN] && !ctl_wr) |=> (ctl_q[CTL_EN] && !pend_q));

  assert_irq_needs_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ctl_q[CTL_IE]));

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic [NCH-1:0]  req,
  output logic            any,
  output logic [CH_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pick_any,
  input  logic [CH_W-1:0] pick_idx,
  input  logic [31:0]     ch_src,
  input  logic [31:0]     ch_dst,
  input  logic            ch_word,
  input  logic            ch_last,
  output logic [CH_W-1:0] act_ch,
  output logic            busy,
  output logic            unit_done,
  output logic            bus_req,
  output logic            bus_we,
  output logic            bus_word,
  output logic [31:0]     bus_addr,
  output logic [31:0]     bus_wdata,
  input  logic [31:0]     bus_rdata,
  input  logic            bus_ack
);

  mv_state_e       state_q, state_d;
  logic [CH_W-1:0] act_q, act_d;
  logic [31:0]     data_q, data_d, amask;

  always_comb begin
    state_d   = state_q;
    act_d     = act_q;
    data_d    = data_q;
    unit_done = 1'b0;
    case (state_q)
      MV_IDLE: if (pick_any) begin
        act_d   = pick_idx;
        state_d = MV_READ;
      end
      MV_READ: if (bus_ack) begin
        data_d  = bus_rdata;
        state_d = MV_WRITE;
      end
      MV_WRITE: if (bus_ack) begin
        unit_done = 1'b1;
        state_d   = ch_last ? MV_IDLE : MV_READ;
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      act_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      data_q  <= data_d;
    end
  end

  assign amask     = ch_word ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
  assign act_ch    = act_q;
  assign busy      = (state_q != MV_IDLE);
  assign bus_req   = (state_q != MV_IDLE);
  assign bus_we    = (state_q == MV_WRITE);
  assign bus_word  = ch_word;
  assign bus_addr  = ((state_q == MV_WRITE) ? ch_dst : ch_src) & amask;
  assign bus_wdata = data_q;

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (!bus_addr[0] && (!bus_word || !bus_addr[1])));

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SHORT_MAX = 16384,
  parameter int LONG_MAX  = 65536,
  localparam int CH_W     = $clog2(NCH),
  localparam int CNT_W    = $clog2(LONG_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_ch,
  input  logic [1:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [1:0]      rd_sel,
  output logic [31:0]     rd_data,
  input  logic            hblank_pulse,
  input  logic            vblank_pulse,
  output logic            bus_req,
  output logic            bus_we,
  output logic            bus_word,
  output logic [31:0]     bus_addr,
  output logic [31:0]     bus_wdata,
  input  logic [31:0]     bus_rdata,
  input  logic            bus_ack,
  output logic [NCH-1:0]  irq
);

  logic [NCH-1:0]  pend, word, last;
  logic [31:0]     wsrc [NCH], wdst [NCH], src_r [NCH], dst_r [NCH];
  logic [15:0]     cnt_r [NCH], ctl_r [NCH];
  logic            pick_any, busy, unit_done;
  logic [CH_W-1:0] pick_idx, act_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma4_chan #(
      .CNT_W    (CNT_W),
      .ZERO_CNT ((g == NCH - 1) ? LONG_MAX : SHORT_MAX)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_ch == CH_W'(g))),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .hblank    (hblank_pulse),
      .vblank    (vblank_pulse),
      .active    (busy && (act_ch == CH_W'(g))),
      .unit_done (unit_done),
      .pend_o    (pend[g]),
      .wsrc_o    (wsrc[g]),
      .wdst_o    (wdst[g]),
      .word_o    (word[g]),
      .last_o    (last[g]),
      .src_reg_o (src_r[g]),
      .dst_reg_o (dst_r[g]),
      .cnt_reg_o (cnt_r[g]),
      .ctl_reg_o (ctl_r[g]),
      .irq_o     (irq[g])
    );
  end

  dma4_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .req (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  dma4_mover #(.CH_W(CH_W)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx),
    .ch_src    (wsrc[act_ch]),
    .ch_dst    (wdst[act_ch]),
    .ch_word   (word[act_ch]),
    .ch_last   (last[act_ch]),
    .act_ch    (act_ch),
    .busy      (busy),
    .unit_done (unit_done),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_SRC: rd_data = src_r[rd_ch];
      SEL_DST: rd_data = dst_r[rd_ch];
      SEL_CNT: rd_data = {16'h0, cnt_r[rd_ch]};
      default: rd_data = {16'h0, ctl_r[rd_ch]};
    endcase
  end

  assert_single_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_irq_only_after_unit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(unit_done));

endmodule

// File: tb/dma4_engine_bench.sv
`timescale 1ns/1ps
module dma4_engine_bench;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0, cfg_sel = '0, rd_ch = '0, rd_sel = '0;
  logic [31:0] cfg_wdata = '0, rd_data, bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        hblank_pulse = 1'b0, vblank_pulse = 1'b0;
  logic        bus_req, bus_we, bus_word;
  logic        bus_ack = 1'b0;
  logic [3:0]  irq;

  int   checks = 0, errors = 0, n_txn = 0, cyc = 0;
  int   irq_cnt [4] = '{0, 0, 0, 0};
  txn_t expq [$];

  always #2 clk = ~clk;

  dma4_engine u_dma4_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .hblank_pulse(hblank_pulse), .vblank_pulse(vblank_pulse), .bus_req(bus_req),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
  );

  function automatic logic [31:0] rmem(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor and bus slave
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_rdata = rmem(bus_addr);
      bus_ack   = 1'b1;
      n_txn++;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected txn actual=%h/%0d expected=none", bus_addr, bus_we);
      end else begin
        txn_t e;
        e = expq.pop_front();
        if (bus_we !== e.we || bus_addr !== e.addr || (e.we && bus_wdata !== e.data)) begin
          errors++;
          $display("FAIL R8 txn actual=%0d/%h/%h expected=%0d/%h/%h",
                   bus_we, bus_addr, bus_wdata, e.we, e.addr, e.data);
        end
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    for (int i = 0; i < 4; i++) if (irq[i] === 1'b1) irq_cnt[i]++;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: expected unit pushed to the scoreboard
  task automatic push_unit(input logic [31:0] s, input logic [31:0] d, input logic w);
    logic [31:0] m;
    m = w ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
    expq.push_back('{we: 1'b0, addr: s & m, data: 32'h0});
    expq.push_back('{we: 1'b1, addr: d & m, data: rmem(s & m)});
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk);
    rd_ch = 2'(ch); rd_sel = 2'(sel);
    #1 v = rd_data;
  endtask

  task automatic pulse(input bit vb);
    @(negedge clk);
    if (vb) vblank_pulse = 1'b1; else hblank_pulse = 1'b1;
    @(negedge clk);
    vblank_pulse = 1'b0; hblank_pulse = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int          base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    @(negedge clk);
    check("R12 bus_req", {31'b0, bus_req}, 32'h0);
    check("R12 irq", {28'b0, irq}, 32'h0);
    rd(0, 3, v); check("R12 ctl0", v, 32'h0);
    rd(3, 0, v); check("R12 src3", v, 32'h0);

    // T1: ch3 immediate word incrementing, misaligned, IE, low bits set
    wr(3, 0, 32'h1000_0007);
    rd(3, 0, v); check("R1 src bit0", v, 32'h1000_0006);
    wr(3, 1, 32'h2000_0001);
    rd(3, 1, v); check("R1 dst bit0", v, 32'h2000_0000);
    wr(3, 2, 32'd3);
    push_unit(32'h1000_0006, 32'h2000_0000, 1'b1);  // R2 R3 increment
    push_unit(32'h1000_000A, 32'h2000_0004, 1'b1);
    push_unit(32'h1000_000E, 32'h2000_0008, 1'b1);
    wr(3, 3, 32'h0000_C41F);                         // R6 immediate start
    drain();
    rd(3, 3, v); check("R9 ctl masked", v, 32'h0000_4400);
    check("R11 irq3 pulse", irq_cnt[3], 1);

    // T2: ch1 halfword, source decrement, destination fixed, no IE
    wr(1, 0, 32'h3000_0010);
    wr(1, 1, 32'h4000_0020);
    wr(1, 2, 32'd2);
    push_unit(32'h3000_0010, 32'h4000_0020, 1'b0);  // R3 decrement / fixed
    push_unit(32'h3000_000E, 32'h4000_0020, 1'b0);
    wr(1, 3, 32'h0000_80C0);
    drain();
    check("R11 irq1 none", irq_cnt[1], 0);
    rd(1, 3, v); check("R9 ctl1", v, 32'h0000_00C0);

    // T3: vblank channels 2 and 0, shadow copies, ordering
    wr(2, 0, 32'h5000_0100); wr(2, 1, 32'h5000_0200); wr(2, 2, 32'd1);
    wr(2, 3, 32'h0000_9400);
    wr(0, 0, 32'h6000_0000); wr(0, 1, 32'h6000_0100); wr(0, 2, 32'd1);
    wr(0, 3, 32'h0000_9000);
    wr(0, 0, 32'h6000_0F00);                         // R5 ignored by armed run
    wr(0, 2, 32'd5);
    base = n_txn;
    pulse(1'b0);
    repeat (20) @(negedge clk);
    check("R6 hblank no start", n_txn - base, 0);
    push_unit(32'h6000_0000, 32'h6000_0100, 1'b0);  // R7 channel 0 first
    push_unit(32'h5000_0100, 32'h5000_0200, 1'b1);
    pulse(1'b1);
    drain();
    check("R7 vblank txns", n_txn - base, 4);
    rd(0, 3, v); check("R9 ctl0", v, 32'h0000_1000);

    // T4: repeating hblank channels 1 (dst reload) and 2 (dst increment)
    wr(1, 0, 32'h7000_0000); wr(1, 1, 32'h7100_0000); wr(1, 2, 32'd2);
    wr(1, 3, 32'h0000_E260);
    wr(2, 0, 32'h7200_0000); wr(2, 1, 32'h7300_0000); wr(2, 2, 32'd1);
    wr(2, 3, 32'h0000_A600);
    push_unit(32'h7000_0000, 32'h7100_0000, 1'b0);
    push_unit(32'h7000_0002, 32'h7100_0002, 1'b0);
    push_unit(32'h7200_0000, 32'h7300_0000, 1'b1);
    pulse(1'b0);
    drain();
    push_unit(32'h7000_0004, 32'h7100_0000, 1'b0);  // R10 destination reloaded
    push_unit(32'h7000_0006, 32'h7100_0002, 1'b0);
    push_unit(32'h7200_0004, 32'h7300_0004, 1'b1);  // R10 no reload in mode 0
    pulse(1'b0);
    drain();
    rd(1, 3, v); check("R10 enable kept", v, 32'h0000_E260);
    check("R11 irq1 repeat pulses", irq_cnt[1], 2);
    wr(1, 3, 32'h0); wr(2, 3, 32'h0);

    // T5: trigger code 3 never starts
    wr(0, 3, 32'h0000_B000);
    base = n_txn;
    pulse(1'b1); pulse(1'b0);
    repeat (20) @(negedge clk);
    check("R6 special silent", n_txn - base, 0);
    wr(0, 3, 32'h0);

    // T6: zero count on channel 0 is 0x4000 units
    wr(0, 0, 32'h0800_0000); wr(0, 1, 32'h0900_0000); wr(0, 2, 32'd0);
    for (int i = 0; i < 16384; i++) push_unit(32'h0800_0000, 32'h0900_0000, 1'b0);
    base = n_txn;
    wr(0, 3, 32'h0000_8140);
    drain();
    check("R4 zero count units", n_txn - base, 32768);
    rd(0, 3, v); check("R4 ctl0 done", v, 32'h0000_0140);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule